// File: doc/BRIEF.md
# DMA Channel State and Error Tracker

This block keeps the run state of a single DMA channel and presents it as a read-only 32-bit status word. It watches register writes aimed at the channel (its control register, its other registers and its flow-control port registers) together with event pulses from the data mover: transfer completion, a bus fault while reading the source and a bus fault while writing the destination. Two level inputs report whether the source or destination flow-control port is signalling a peripheral transfer error. The data mover itself, address generation and the bus protocol sit outside this block.

The control register holds a 2-bit enable field in bits 1:0 and a 3-bit transfer-kind field in bits 4:2; higher bits are further configuration that is only compared, never decoded. A valid enable write starts a transfer; rewriting the control register with only the enable field changed pauses or resumes it. Any fault lands the channel in an error state with a flag naming the cause, and a write to one of the channel's other registers clears it back to idle. A status word whose bits 23:16 and 1:0 are all zero means the previous transfer finished cleanly.

Top module: `dma_chan_tracker`

## Requirements
- R1: After synchronous reset the status word is all zeros and `busy_o` is 0.
- R2: Status bits 1:0 carry the state: 00 idle, 01 busy, 10 paused, 11 error. A control write with a non-zero enable field (bits 1:0), a valid kind and no flow-control error, made from idle, paused or error, moves the state to 01 with every error flag cleared.
- R3: In busy, a control write with enable field 00 and every other bit equal to the last control value written moves the state to 10.
- R4: In paused, a control write with a non-zero enable field and every other bit equal to the last control value moves the state back to 01.
- R5: In paused or error, a write to another channel register or to a flow-control port register moves the state to 00 with all error flags cleared.
- R6: In busy, a source read bus fault sets bit 20 and a destination write bus fault sets bit 16; either moves the state to 11.
- R7: An enabling control write while the source flow-control error input is high sets bit 21, and while the destination one is high sets bit 17; the state goes to 11 and never passes through 01.
- R8: In busy, a write to another channel register, to a flow-control port register, or a control write that is not the pause form sets bit 22 and moves the state to 11.
- R9: An enabling control write whose kind field (bits 4:2) is 6 or 7 (at or above parameter `BAD_KIND_MIN`, default 6) sets bit 23 and moves the state to 11; from error, earlier flags are kept.
- R10: In busy, a completion pulse with no fault or write in the same cycle moves the state to 00 with all error flags cleared.
- R11: Bits 15:2, 19:18 and 31:24 always read 0, `busy_o` is 1 exactly when the state is 01, and the state is 11 exactly when some error flag is set.
- R12: Outside busy, completion pulses and bus faults have no effect; in idle or error, a control write with enable field 00 has no effect on the status word.
- R13: In paused, a control write with a non-zero enable field and other bits changed is judged as a fresh enable, and one with enable field 00 moves the state to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| other_wr_i | input | 1 | Write strobe for any other channel register |
| fc_wr_i | input | 1 | Write strobe for a flow-control port register |
| wr_data_i | input | CTRL_W | Data of a control write |
| xfer_done_i | input | 1 | Transfer completion pulse |
| src_rd_err_i | input | 1 | Bus fault while reading the source |
| dst_wr_err_i | input | 1 | Bus fault while writing the destination |
| src_fc_err_i | input | 1 | Source flow-control port signals a transfer error |
| dst_fc_err_i | input | 1 | Destination flow-control port signals a transfer error |
| status_o | output | 32 | Status word: state and error flags |
| busy_o | output | 1 | High while the channel is busy |

## Verification
The assertions take for granted that at most one of the three write strobes is high in a cycle, since one register port serves all of them; this is itself checked as an assertion. The random stimulus picks at most one write kind per cycle, draws control data from values close to the last one written so that pause and resume forms occur often, and raises faults and flow-control errors rarely enough that transfers run long enough to be paused, resumed and completed.

// File: rtl/dcst_pkg.sv
package dcst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BUSY  = 2'b01,
        ST_PAUSE = 2'b10,
        ST_FAULT = 2'b11
    } chan_state_e;

    typedef struct packed {
        logic cfg_bad;
        logic upd;
        logic src_fc;
        logic rd_bus;
        logic dst_fc;
        logic wr_bus;
    } err_flags_t;

    typedef struct packed {
        logic en_on;
        logic rest_same;
        logic kind_bad;
    } ctrl_dec_t;

    localparam int EN_LSB   = 0;
    localparam int EN_W     = 2;
    localparam int KIND_LSB = 2;
    localparam int KIND_W   = 3;

    localparam logic [31:0] STATUS_RSV_MASK = 32'hFF0C_FFFC;

    function automatic logic [31:0] pack_status(chan_state_e st, err_flags_t e);
        logic [31:0] w;
        w      = '0;
        w[1:0] = st;
        w[16]  = e.wr_bus;
        w[17]  = e.dst_fc;
        w[20]  = e.rd_bus;
        w[21]  = e.src_fc;
        w[22]  = e.upd;
        w[23]  = e.cfg_bad;
        return w;
    endfunction

endpackage

// File: rtl/dcst_decode.sv
module dcst_decode
    import dcst_pkg::*;
#(
    parameter int CTRL_W       = 16,
    parameter int BAD_KIND_MIN = 6
) (
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic [CTRL_W-1:0] ctrl_q_i,
    output ctrl_dec_t         dec_o
);
    localparam logic [CTRL_W-1:0] EN_MASK = CTRL_W'(((1 << EN_W) - 1) << EN_LSB);

    logic [KIND_W-1:0] kind;

    always_comb begin
        kind            = wr_data_i[KIND_LSB +: KIND_W];
        dec_o.en_on     = |wr_data_i[EN_LSB +: EN_W];
        dec_o.rest_same = ((wr_data_i ^ ctrl_q_i) & ~EN_MASK) == '0;
        dec_o.kind_bad  = kind >= KIND_W'(BAD_KIND_MIN);
    end

endmodule

// File: rtl/dcst_fsm.sv
module dcst_fsm
    import dcst_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr_i,
    input  logic              other_wr_i,
    input  logic              fc_wr_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  ctrl_dec_t         dec_i,
    input  logic              xfer_done_i,
    input  logic              src_rd_err_i,
    input  logic              dst_wr_err_i,
    input  logic              src_fc_err_i,
    input  logic              dst_fc_err_i,
    output chan_state_e       st_o,
    output err_flags_t        err_o,
    output logic [CTRL_W-1:0] ctrl_q_o
);
    chan_state_e       st_q, st_d;
    err_flags_t        err_q, err_d;
    logic [CTRL_W-1:0] ctrl_q;
    err_flags_t        en_err, run_err;
    logic              en_fail, side_wr, pause_form;

    always_comb begin
        en_err  = '{cfg_bad: dec_i.kind_bad, upd: 1'b0, src_fc: src_fc_err_i,
                    rd_bus: 1'b0, dst_fc: dst_fc_err_i, wr_bus: 1'b0};
        en_fail = |en_err;
        side_wr = other_wr_i | fc_wr_i;
        pause_form = ctrl_wr_i & ~dec_i.en_on & dec_i.rest_same;
        run_err = '{cfg_bad: 1'b0, upd: (ctrl_wr_i & ~pause_form) | side_wr,
                    src_fc: 1'b0, rd_bus: src_rd_err_i, dst_fc: 1'b0,
                    wr_bus: dst_wr_err_i};
        st_d  = st_q;
        err_d = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ctrl_wr_i && dec_i.en_on) begin
                    st_d  = en_fail ? ST_FAULT : ST_BUSY;
                    err_d = en_fail ? en_err : '0;
                end
            end
            ST_BUSY: begin
                if (|run_err) begin
                    st_d  = ST_FAULT;
                    err_d = run_err;
                end else if (pause_form) begin
                    st_d = ST_PAUSE;
                end else if (xfer_done_i) begin
                    st_d  = ST_IDLE;
                    err_d = '0;
                end
            end
            ST_PAUSE: begin
                if (side_wr) begin
                    st_d  = ST_IDLE;
                    err_d = '0;
                end else if (ctrl_wr_i) begin
                    if (dec_i.en_on) begin
                        st_d  = en_fail ? ST_FAULT : ST_BUSY;
                        err_d = en_fail ? en_err : '0;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_FAULT: begin
                if (side_wr) begin
                    st_d  = ST_IDLE;
                    err_d = '0;
                end else if (ctrl_wr_i && dec_i.en_on) begin
                    st_d  = en_fail ? ST_FAULT : ST_BUSY;
                    err_d = en_fail ? err_flags_t'(err_q | en_err) : '0;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                err_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= err_d;
    end

    always_ff @(posedge clk) begin
        if (rst)            ctrl_q <= '0;
        else if (ctrl_wr_i) ctrl_q <= wr_data_i;
    end

    assign st_o     = st_q;
    assign err_o    = err_q;
    assign ctrl_q_o = ctrl_q;

    // R11
    fault_iff_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FAULT) == (err_q != '0));

    // R3
    pause_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && ctrl_wr_i && !dec_i.en_on && dec_i.rest_same &&
         !src_rd_err_i && !dst_wr_err_i) |=> st_q == ST_PAUSE);

    // R5
    side_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_PAUSE || st_q == ST_FAULT) && (other_wr_i || fc_wr_i))
        |=> (st_q == ST_IDLE && err_q == '0));

    // R6
    rd_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && src_rd_err_i) |=> (st_q == ST_FAULT && err_q.rd_bus));

    // R7
    fc_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && ctrl_wr_i && dec_i.en_on && (src_fc_err_i || dst_fc_err_i))
        |=> st_q == ST_FAULT);

    // R8
    busy_update_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && (other_wr_i || fc_wr_i)) |=> (st_q == ST_FAULT && err_q.upd));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && xfer_done_i && !ctrl_wr_i && !other_wr_i && !fc_wr_i &&
         !src_rd_err_i && !dst_wr_err_i) |=> (st_q == ST_IDLE && err_q == '0));

endmodule

// File: rtl/dcst_status.sv
module dcst_status
    import dcst_pkg::*;
(
    input  chan_state_e st_i,
    input  err_flags_t  err_i,
    output logic [31:0] status_o,
    output logic        busy_o
);
    always_comb begin
        status_o = pack_status(st_i, err_i);
        busy_o   = (st_i == ST_BUSY);
    end
endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
    import dcst_pkg::*;
#(
    parameter int CTRL_W       = 16,
    parameter int BAD_KIND_MIN = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr_i,
    input  logic              other_wr_i,
    input  logic              fc_wr_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              xfer_done_i,
    input  logic              src_rd_err_i,
    input  logic              dst_wr_err_i,
    input  logic              src_fc_err_i,
    input  logic              dst_fc_err_i,
    output logic [31:0]       status_o,
    output logic              busy_o
);
    ctrl_dec_t         dec;
    chan_state_e       st;
    err_flags_t        err;
    logic [CTRL_W-1:0] ctrl_q;

    dcst_decode #(.CTRL_W(CTRL_W), .BAD_KIND_MIN(BAD_KIND_MIN)) decode_i (
        .wr_data_i (wr_data_i),
        .ctrl_q_i  (ctrl_q),
        .dec_o     (dec)
    );

    dcst_fsm #(.CTRL_W(CTRL_W)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr_i    (ctrl_wr_i),
        .other_wr_i   (other_wr_i),
        .fc_wr_i      (fc_wr_i),
        .wr_data_i    (wr_data_i),
        .dec_i        (dec),
        .xfer_done_i  (xfer_done_i),
        .src_rd_err_i (src_rd_err_i),
        .dst_wr_err_i (dst_wr_err_i),
        .src_fc_err_i (src_fc_err_i),
        .dst_fc_err_i (dst_fc_err_i),
        .st_o         (st),
        .err_o        (err),
        .ctrl_q_o     (ctrl_q)
    );

    dcst_status status_i (
        .st_i     (st),
        .err_i    (err),
        .status_o (status_o),
        .busy_o   (busy_o)
    );

    // R11
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o & STATUS_RSV_MASK) == 32'h0);

    // R11
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o == (status_o[1:0] == 2'b01));

    // single register port: one write strobe per cycle
    one_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_wr_i, other_wr_i, fc_wr_i}));

endmodule

// File: tb/dma_chan_tracker_tb_top.sv
module dma_chan_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctrl_wr, other_wr, fc_wr;
    logic [CW-1:0] wdata;
    logic          done, rderr, wrerr, sfc, dfc;
    logic [31:0]   status;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1:0]    m_st;
    logic [5:0]    m_err;   // [5]cfg [4]upd [3]srcfc [2]rd [1]dstfc [0]wr
    logic [CW-1:0] m_ctrl;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_tracker #(.CTRL_W(CW), .BAD_KIND_MIN(6)) dut_i (
        .clk(clk), .rst(rst), .ctrl_wr_i(ctrl_wr), .other_wr_i(other_wr),
        .fc_wr_i(fc_wr), .wr_data_i(wdata), .xfer_done_i(done),
        .src_rd_err_i(rderr), .dst_wr_err_i(wrerr), .src_fc_err_i(sfc),
        .dst_fc_err_i(dfc), .status_o(status), .busy_o(busy)
    );

    function automatic logic [31:0] exp_status(logic [1:0] st, logic [5:0] e);
        logic [31:0] w = '0;
        w[1:0] = st; w[16] = e[0]; w[17] = e[1]; w[20] = e[2];
        w[21] = e[3]; w[22] = e[4]; w[23] = e[5];
        return w;
    endfunction

    // returns {state, flags} for an enabling control write
    function automatic logic [7:0] enable_result(logic [5:0] base, logic [CW-1:0] d,
                                                 logic s, logic dd);
        logic [5:0] n;
        n = {(d[4:2] >= 3'd6), 1'b0, s, 1'b0, dd, 1'b0};
        if (n != 0) return {2'b11, base | n};
        return {2'b01, 6'b0};
    endfunction

    task automatic model_step();
        logic en_on, same, upd;
        logic [5:0] f;
        logic [7:0] r;
        en_on = wdata[1:0] != 2'b00;
        same  = ((wdata ^ m_ctrl) & ~16'h0003) == 16'h0;
        case (m_st)
            2'b00: if (ctrl_wr && en_on) begin
                r = enable_result(6'b0, wdata, sfc, dfc); m_st = r[7:6]; m_err = r[5:0];
            end
            2'b01: begin
                upd = (ctrl_wr && !(!en_on && same)) || other_wr || fc_wr;
                f = {1'b0, upd, 1'b0, rderr, 1'b0, wrerr};
                if (f != 0) begin m_st = 2'b11; m_err = f; end
                else if (ctrl_wr) m_st = 2'b10;
                else if (done) begin m_st = 2'b00; m_err = 0; end
            end
            2'b10: begin
                if (other_wr || fc_wr) begin m_st = 2'b00; m_err = 0; end
                else if (ctrl_wr) begin
                    if (en_on) begin
                        r = enable_result(6'b0, wdata, sfc, dfc); m_st = r[7:6]; m_err = r[5:0];
                    end else m_st = 2'b00;
                end
            end
            default: begin
                if (other_wr || fc_wr) begin m_st = 2'b00; m_err = 0; end
                else if (ctrl_wr && en_on) begin
                    r = enable_result(m_err, wdata, sfc, dfc); m_st = r[7:6]; m_err = r[5:0];
                end
            end
        endcase
        if (ctrl_wr) m_ctrl = wdata;
    endtask

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ctrl_wr = 0; other_wr = 0; fc_wr = 0; done = 0;
        rderr = 0; wrerr = 0; sfc = 0; dfc = 0;
    endtask

    // apply inputs for one cycle, advance the model, sample just after the edge
    task automatic cyc(logic c, logic o, logic f, logic [CW-1:0] d,
                       logic dn, logic re, logic we, logic s, logic dd);
        ctrl_wr = c; other_wr = o; fc_wr = f; wdata = d; done = dn;
        rderr = re; wrerr = we; sfc = s; dfc = dd;
        @(posedge clk);
        #1;
        model_step();
        idle_inputs();
    endtask

    task automatic ctl(logic [CW-1:0] d);
        cyc(1, 0, 0, d, 0, 0, 0, 0, 0);
    endtask

    task automatic oth();
        cyc(0, 1, 0, m_ctrl, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        wdata = '0;
        rst = 1;
        m_st = 0; m_err = 0; m_ctrl = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check32("R1 reset status", status, 32'h0);
        check32("R1 reset busy", {31'b0, busy}, 32'h0);

        ctl(16'h1105);                       // enable=01, kind=1
        check32("R2 valid enable", status, 32'h0000_0001);
        check32("R11 busy high", {31'b0, busy}, 32'h1);
        ctl(16'h1104);                       // enable=00, rest same
        check32("R3 pause", status, 32'h0000_0002);
        check32("R11 busy low in pause", {31'b0, busy}, 32'h0);
        cyc(0, 0, 0, m_ctrl, 1, 1, 1, 0, 0);
        check32("R12 events ignored in pause", status, 32'h0000_0002);
        ctl(16'h1106);                       // enable=10, rest same
        check32("R4 resume", status, 32'h0000_0001);
        cyc(0, 0, 0, m_ctrl, 1, 0, 0, 0, 0);
        check32("R10 done", status, 32'h0);
        cyc(0, 0, 0, m_ctrl, 1, 1, 1, 0, 0);
        check32("R12 events ignored in idle", status, 32'h0);

        ctl(16'h0009);
        cyc(0, 0, 0, m_ctrl, 0, 1, 0, 0, 0);
        check32("R6 read bus fault", status, 32'h0010_0003);
        ctl(16'h0008);
        check32("R12 enable 00 in error", status, 32'h0010_0003);
        oth();
        check32("R5 other write clears error", status, 32'h0);
        ctl(16'h0009);
        cyc(0, 0, 0, m_ctrl, 0, 0, 1, 0, 0);
        check32("R6 write bus fault", status, 32'h0001_0003);
        cyc(0, 0, 1, m_ctrl, 0, 0, 0, 0, 0);
        check32("R5 fc write clears error", status, 32'h0);

        cyc(1, 0, 0, 16'h0005, 0, 0, 0, 1, 0);
        check32("R7 source fc error", status, 32'h0020_0003);
        check32("R7 never busy", {31'b0, busy}, 32'h0);
        oth();
        cyc(1, 0, 0, 16'h0005, 0, 0, 0, 0, 1);
        check32("R7 dest fc error", status, 32'h0002_0003);
        ctl(16'h0005);
        check32("R2 valid enable from error clears flags", status, 32'h0000_0001);

        ctl(16'h0009);                        // busy, control write not pause form
        check32("R8 update by control write", status, 32'h0040_0003);
        oth();
        ctl(16'h0005);
        oth();
        check32("R8 update by other write", status, 32'h0040_0003);
        oth();

        ctl(16'h0019);                        // kind=6
        check32("R9 kind 6 invalid", status, 32'h0080_0003);
        cyc(1, 0, 0, 16'h001D, 0, 0, 0, 1, 0); // kind=7 plus fc, from error
        check32("R9 flags kept and added", status, 32'h00A0_0003);
        oth();

        ctl(16'h0005);
        ctl(16'h0004);
        ctl(16'h0209);                        // changed rest, valid enable
        check32("R13 changed enable from pause", status, 32'h0000_0001);
        ctl(16'h0208);
        ctl(16'h0300);                        // enable 00, changed rest
        check32("R13 disable from pause", status, 32'h0);

        // random phase
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED_0042);
        end
        for (int i = 0; i < 4000; i++) begin
            int sel;
            logic [CW-1:0] d;
            sel = $urandom_range(0, 15);
            d = m_ctrl;
            case ($urandom_range(0, 3))
                0: d[1:0] = 2'($urandom_range(0, 3));
                1: begin d[1:0] = 2'($urandom_range(0, 3)); d[4:2] = 3'($urandom_range(0, 7)); end
                2: d = 16'($urandom);
                default: d[1:0] = 2'b00;
            endcase
            cyc(sel < 4, sel == 4, sel == 5, d,
                $urandom_range(0, 5) == 0, $urandom_range(0, 19) == 0,
                $urandom_range(0, 19) == 0, $urandom_range(0, 9) == 0,
                $urandom_range(0, 9) == 0);
            check32("model status", status, exp_status(m_st, m_err));
            check32("R11 reserved zero", status & 32'hFF0C_FFFC, 32'h0);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule